// File: doc/BRIEF.md
# LCD Pixel Clock Generator

This block derives the panel pixel clock from a faster reference clock. A 5-bit divisor field selects an integer ratio equal to the field value plus two, which gives ratios from 2 to 33. A bypass bit skips the divider, so the pixel clock then runs at the reference rate. The pixel clock does not run freely. Each line-start pulse opens a burst of exactly the programmed number of pixel clock pulses. When the burst ends, the clock rests low and a line-done flag rises.

A one-cycle launch strobe goes to the pixel data path. Its timing follows an edge-select bit, so the data path can launch on either the rising or the falling edge of the pixel clock. The bypass, edge-select and clocks-per-line fields are captured at line start. The divisor is captured at line start and again at each pixel clock period boundary, so a change to it never shortens a pulse in flight.

Top module: `lcd_pclk_gen`

## Requirements
- R1: With bypass clear, each pixel clock period lasts div_i + 2 reference cycles, where div_i is read as an unsigned binary value from 0 to 31.
- R2: The pixel clock is high for (N+1)/2 reference cycles and low for N/2 reference cycles of each period of N cycles, with integer division. For odd N the high phase is therefore one cycle longer.
- R3: The first reference edge that samples line_start_i high starts a burst of exactly cpl_i + 1 pixel clock pulses. The first pulse goes high on that edge. A new line_start_i restarts the count, and pclk_o stays low once the burst is over.
- R4: launch_o is high for exactly one reference cycle per pixel clock pulse. With edge_sel_i = 0 it is high in the cycle in which pclk_o has just risen. With edge_sel_i = 1 it is high in the cycle in which pclk_o has just fallen.
- R5: line_done_o goes high on the reference edge that ends a burst. It stays high until the next line start clears it.
- R6: div_i is sampled only at line start and at the reference edge that ends a pixel clock period. A change in the middle of a period does not affect that period.
- R7: With bypass_i = 1 at line start, pclk_o is clk_i gated for cpl_i + 1 consecutive reference cycles, beginning with the first rising edge after line start. During that window launch_o is held high.
- R8: While rst_ni is low and after reset, pclk_o, launch_o and line_done_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_start_i | input | 1 | One-cycle pulse that starts a line burst |
| div_i | input | 5 | Divisor field; ratio is value + 2 |
| bypass_i | input | 1 | 1: pixel clock taken straight from the reference clock |
| edge_sel_i | input | 1 | 0: launch on rising edge, 1: launch on falling edge |
| cpl_i | input | 10 | Pixel clocks per line minus one |
| pclk_o | output | 1 | Pixel clock to the panel |
| launch_o | output | 1 | Data-launch strobe for the pixel data path |
| line_done_o | output | 1 | High once the line burst has completed |

## Verification
The assertions check the following on every cycle:
- the ratio register stays in the legal range while running, and holds inside a period;
- the pulse counter never passes its limit;
- the launch strobe only accompanies a real transition of the pixel clock;
- the clock is low whenever no burst runs;
- the done flag excludes a running burst.

Some properties can only be shown by the bench's scenarios against its own period model:
- the exact high and low phase lengths for odd ratios;
- the total pulse count per line;
- correct edge selection;
- the effect of a mid-period divisor change;
- the gated reference clock in bypass.

// File: rtl/lcd_pclk_pkg.sv
package lcd_pclk_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } launch_edge_e;

  localparam int unsigned DIV_OFS = 2;
endpackage

// File: rtl/lcd_pclk_period.sv
module lcd_pclk_period
  import lcd_pclk_pkg::*;
#(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             stop_i,
  input  logic [DIV_W-1:0] div_i,
  input  launch_edge_e     edge_i,
  output logic             pclk_o,
  output logic             launch_o,
  output logic             last_o
);
  localparam int unsigned R_W   = DIV_W + 1;
  localparam int unsigned R_MAX = (2 ** DIV_W) - 1 + DIV_OFS;

  logic [R_W-1:0] phase_q, ratio_q, ratio_in, phase_nx;
  logic [R_W:0]   hi_len;
  logic           pclk_q, launch_q;

  assign ratio_in = R_W'(div_i) + R_W'(DIV_OFS);
  assign phase_nx = phase_q + R_W'(1);
  // odd ratios: high phase gets the extra cycle
  assign hi_len   = ({1'b0, ratio_q} + (R_W+1)'(1)) >> 1;
  assign last_o   = run_i && (phase_q == ratio_q - R_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= '0;
      ratio_q  <= R_W'(DIV_OFS);
      pclk_q   <= 1'b0;
      launch_q <= 1'b0;
    end else if (start_i) begin
      phase_q  <= '0;
      ratio_q  <= ratio_in;
      pclk_q   <= 1'b1;
      launch_q <= (edge_i == EDGE_RISE);
    end else if (run_i) begin
      if (last_o) begin
        phase_q <= '0;
        if (stop_i) begin
          pclk_q   <= 1'b0;
          launch_q <= 1'b0;
        end else begin
          ratio_q  <= ratio_in;
          pclk_q   <= 1'b1;
          launch_q <= (edge_i == EDGE_RISE);
        end
      end else begin
        phase_q  <= phase_nx;
        pclk_q   <= ({1'b0, phase_nx} < hi_len);
        launch_q <= (edge_i == EDGE_FALL) && ({1'b0, phase_nx} == hi_len);
      end
    end else begin
      phase_q  <= '0;
      pclk_q   <= 1'b0;
      launch_q <= 1'b0;
    end
  end

  assign pclk_o   = pclk_q;
  assign launch_o = launch_q;

  a_r1_ratio_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (ratio_q >= R_W'(DIV_OFS)) && (32'(ratio_q) <= R_MAX));

  a_r6_ratio_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i && !last_o) |=> $stable(ratio_q));

  a_r4_launch_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_q && !$past(start_i)) |-> (pclk_q != $past(pclk_q)));
endmodule

// File: rtl/lcd_pclk_burst.sv
module lcd_pclk_burst #(
  parameter int unsigned CPL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [CPL_W-1:0] cpl_i,
  output logic             run_o,
  output logic             stop_o,
  output logic             done_o
);
  logic [CPL_W-1:0] cpl_q, cnt_q;
  logic             run_q, done_q;

  assign stop_o = run_q && tick_i && (cnt_q == cpl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpl_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      cpl_q  <= cpl_i;
      cnt_q  <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (stop_o) begin
      run_q  <= 1'b0;
      done_q <= 1'b1;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q + CPL_W'(1);
    end
  end

  assign run_o  = run_q;
  assign done_o = done_q;

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q <= cpl_q));

  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !run_q);

  a_r5_stop_sets_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !start_i) |=> (done_q && !run_q));
endmodule

// File: rtl/lcd_pclk_bypass.sv
module lcd_pclk_bypass (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic pclk_o,
  output logic act_o
);
  logic gate_q;

  // enable changes while clk_i is low: glitch-free gating
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= en_i;
  end

  assign pclk_o = clk_i & gate_q;
  assign act_o  = gate_q;

  a_r7_gate_follow: assert property (@(negedge clk_i) disable iff (!rst_ni)
    en_i |=> gate_q);
endmodule

// File: rtl/lcd_pclk_gen.sv
module lcd_pclk_gen
  import lcd_pclk_pkg::*;
#(
  parameter int unsigned DIV_W = 5,
  parameter int unsigned CPL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             bypass_i,
  input  logic             edge_sel_i,
  input  logic [CPL_W-1:0] cpl_i,
  output logic             pclk_o,
  output logic             launch_o,
  output logic             line_done_o
);
  logic         bypass_q;
  launch_edge_e edge_q, edge_use;
  logic         run, stop, last, tick;
  logic         div_pclk, div_launch, byp_pclk, byp_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bypass_q <= 1'b0;
      edge_q   <= EDGE_RISE;
    end else if (line_start_i) begin
      bypass_q <= bypass_i;
      edge_q   <= launch_edge_e'(edge_sel_i);
    end
  end

  assign edge_use = line_start_i ? launch_edge_e'(edge_sel_i) : edge_q;
  assign tick     = bypass_q | last;

  lcd_pclk_burst #(.CPL_W(CPL_W)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (line_start_i),
    .tick_i  (tick),
    .cpl_i   (cpl_i),
    .run_o   (run),
    .stop_o  (stop),
    .done_o  (line_done_o)
  );

  lcd_pclk_period #(.DIV_W(DIV_W)) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (line_start_i),
    .run_i    (run),
    .stop_i   (stop),
    .div_i    (div_i),
    .edge_i   (edge_use),
    .pclk_o   (div_pclk),
    .launch_o (div_launch),
    .last_o   (last)
  );

  lcd_pclk_bypass u_bypass (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run && bypass_q),
    .pclk_o (byp_pclk),
    .act_o  (byp_act)
  );

  assign pclk_o   = bypass_q ? byp_pclk : div_pclk;
  assign launch_o = bypass_q ? byp_act  : div_launch;

  a_r3_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !line_start_i) |=> !div_pclk);

  a_r5_done_no_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_done_o && !bypass_q) |-> !div_launch);
endmodule

// File: tb/sim_lcd_pclk_gen.sv
module sim_lcd_pclk_gen;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_start_i = 1'b0;
  logic [4:0] div_i = '0;
  logic       bypass_i = 1'b0;
  logic       edge_sel_i = 1'b0;
  logic [9:0] cpl_i = '0;
  logic       pclk_o, launch_o, line_done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  lcd_pclk_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .line_start_i(line_start_i), .div_i(div_i),
    .bypass_i(bypass_i), .edge_sel_i(edge_sel_i), .cpl_i(cpl_i),
    .pclk_o(pclk_o), .launch_o(launch_o), .line_done_o(line_done_o)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int hi_of(input int ratio);
    return (ratio + 1) / 2;
  endfunction

  // divided-mode line against a per-cycle period model; chg<0: no divisor change
  task automatic run_line(input int div, input int cpl, input bit edg,
                          input int div2, input int chg, input string tag);
    int ratio, phase, pcnt, k, extra;
    @(negedge clk);
    div_i = 5'(div); cpl_i = 10'(cpl); edge_sel_i = edg; bypass_i = 1'b0;
    line_start_i = 1'b1;
    @(negedge clk);
    line_start_i = 1'b0;
    ratio = div + 2; phase = 0; pcnt = 0; k = 0; extra = 0;
    while (extra < 3) begin
      int ep, el, ed;
      if (pcnt <= cpl) begin
        ep = (phase < hi_of(ratio)) ? 1 : 0;
        el = edg ? ((phase == hi_of(ratio)) ? 1 : 0) : ((phase == 0) ? 1 : 0);
        ed = 0;
      end else begin
        ep = 0; el = 0; ed = 1; extra++;
      end
      chk_eq({tag, " pclk"}, int'(pclk_o), ep);
      chk_eq("R4 launch", int'(launch_o), el);
      chk_eq("R5 done", int'(line_done_o), ed);
      if (k == chg) div_i = 5'(div2);
      k++; phase++;
      if (phase == ratio) begin
        phase = 0; pcnt++; ratio = int'(div_i) + 2;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_byp(input int cpl);
    @(negedge clk);
    bypass_i = 1'b1; cpl_i = 10'(cpl); line_start_i = 1'b1;
    @(negedge clk);
    line_start_i = 1'b0;
    for (int k = 1; k <= cpl + 3; k++) begin
      @(posedge clk); #2;
      chk_eq("R7 pclk high phase", int'(pclk_o), (k <= cpl + 1) ? 1 : 0);
      chk_eq("R7 launch", int'(launch_o), (k <= cpl + 1) ? 1 : 0);
      chk_eq("R5 done bypass", int'(line_done_o), (k >= cpl + 1) ? 1 : 0);
      #(CLK_P/2);
      chk_eq("R7 pclk low phase", int'(pclk_o), 0);
    end
    bypass_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_P * 3 + 2);
    chk_eq("R8 pclk in reset", int'(pclk_o), 0);
    chk_eq("R8 launch in reset", int'(launch_o), 0);
    chk_eq("R8 done in reset", int'(line_done_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R8 pclk after reset", int'(pclk_o), 0);
    chk_eq("R8 done after reset", int'(line_done_o), 0);

    run_line(0, 0, 1'b0, 0, -1, "R1/R3 min");
    run_line(1, 3, 1'b1, 1, -1, "R2 odd");
    run_line(31, 1, 1'b0, 31, -1, "R1 max");
    run_line(2, 2, 1'b1, 2, -1, "R2 even");
    run_line(4, 2, 1'b0, 0, 2, "R6 mid change");
    run_line(3, 3, 1'b1, 6, 7, "R6 fall change");
    run_line(0, 1023, 1'b0, 0, -1, "R3 full line");
    // R3: restart line with done already set, count starts over
    run_line(5, 4, 1'b0, 5, -1, "R3 restart");
    run_byp(0);
    run_byp(5);
    run_line(2, 1, 1'b1, 2, -1, "R7 back to divided");

    for (int i = 0; i < 30; i++) begin
      int d, c, d2, ch;
      d  = int'($urandom_range(31, 0));
      c  = int'($urandom_range(7, 0));
      d2 = int'($urandom_range(31, 0));
      ch = int'($urandom_range(40, 0)) - 10;
      if (($urandom_range(7, 0)) == 0) run_byp(c);
      else run_line(d, c, 1'($urandom_range(1, 0)), d2, ch, "R1/R2/R3/R6 rand");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule